// File: doc/BRIEF.md
# Frame-Locked Line Clock Generator with Period Stretching

This block produces a line-rate clock and a local 8 kHz frame signal from a master clock that runs slightly faster than eight times the nominal line rate. The master clock reaches the block as a single-cycle enable, `mtick`, at twice the master rate. Each tick is one half master period. Sixteen ticks make one line-clock period. A frame is 193 line periods in T1 length or 256 in CEPT length. The block runs entirely in the `clk` domain.

Once per frame, the selected edge of the 8 kHz reference is compared with the local frame position. Correction works in one direction only. If the local frame is ahead of the reference, two fixed points in the rest of that frame each swallow one tick, which delays the frame by one master period. Otherwise the ticks pass unaltered, and the fast master lets the local frame catch up.

A free-run setting stretches every frame twice without any reference. A divide-only setting counts `mtick` as an external line-rate clock and divides it to an 8 kHz signal. A lock flag reports a run of comparisons that needed no correction.

Top module: `pulse_stretch_dpll`

## Requirements
- R1: While `rst_n` is low, `line_clk`, `frame_8k` and `locked` are 0. Reset clears every counter to zero.
- R2: Outside divide-only, `line_clk` is low for 8 advancing ticks and then high for 8. It goes high on the 8th tick after a line period starts.
- R3: Track mode with no selected reference edge applies no correction. A frame is then exactly N×16 ticks, with N = 193 when `len_cept`=0 and N = 256 when `len_cept`=1. `frame_8k` rises when the frame count reaches 65 (N=193) or 128 (N=256), and it falls when the count wraps to 0.
- R4: A selected reference edge that arrives while the frame count is 0 or at least N/2 (integer division) causes no stretch.
- R5: A selected reference edge that arrives while the frame count is between 1 and N/2−1 arms a stretch. Each stretch point that the current local frame has not yet passed then swallows one tick. The arming ends when the frame count wraps.
- R6: `edge_rise`=0 selects falling reference edges and `edge_rise`=1 selects rising ones. Edges of the other polarity have no effect on the counters or on `locked`.
- R7: When `op_mode`=2'b01 (free run), every frame is stretched at both points. A frame is then N×16+2 ticks.
- R8: When `op_mode[1]`=1 (divide only), every tick advances the frame count by one and `line_clk` stays 0. `frame_8k` is high for 128 of 193 ticks (N=193) or 128 of 256 ticks (N=256).
- R9: `locked` rises after 4 consecutive comparisons that need no stretch. It drops after any comparison that arms a stretch, and it is held at 0 outside track mode (`op_mode`=2'b00).
- R10: The stretch points are frame counts N/4 and 3N/4 (48 and 144, or 64 and 192), at the first tick of that line period. A swallowed tick never follows another swallowed tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mtick | input | 1 | Half-master-period tick (line-clock tick in divide-only) |
| ref_in | input | 1 | 8 kHz reference, synchronous to clk |
| len_cept | input | 1 | 0: 193-period frame, 1: 256-period frame |
| edge_rise | input | 1 | 0: lock to falling edge, 1: lock to rising edge |
| op_mode | input | 2 | 00 track, 01 free run, 1x divide only |
| line_clk | output | 1 | Generated line-rate clock |
| frame_8k | output | 1 | Local 8 kHz frame signal |
| locked | output | 1 | Run of correction-free comparisons seen |

## Verification
The assertions assume the following about the inputs:
- `op_mode`, `len_cept` and `edge_rise` stay constant between resets.
- `ref_in` is already synchronous to `clk`.
- Stretch and lock behaviour is only meaningful when selected reference edges come roughly once per frame.

The stimulus changes the mode inputs only while reset is held. It drives `mtick` on every cycle, so the tick count seen by the bench equals the clock count since reset. It places each reference edge at a frame position well inside the ahead or behind region, so an error of a few ticks in the prediction cannot flip the expected decision.

// File: rtl/pulse_stretch_dpll.sv
module pulse_stretch_dpll #(
  parameter int T1_LEN   = 193,
  parameter int CEPT_LEN = 256,
  parameter int MDIV     = 8,
  parameter int LOCK_RUN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mtick,
  input  logic       ref_in,
  input  logic       len_cept,
  input  logic       edge_rise,
  input  logic [1:0] op_mode,
  output logic       line_clk,
  output logic       frame_8k,
  output logic       locked
);
  localparam int TPL = 2 * MDIV;
  localparam int TW  = $clog2(TPL);
  localparam int FW  = $clog2(CEPT_LEN);
  localparam int LW  = $clog2(LOCK_RUN + 1);
  localparam int T1_HI   = T1_LEN - 2 * (T1_LEN / 3);
  localparam int CEPT_HI = CEPT_LEN / 2;

  logic [TW-1:0] tick_cnt;
  logic [FW-1:0] frame_cnt;
  logic [LW-1:0] good_cnt;
  logic stalled, armed, ref_q, locked_q;

  logic div_mode, free_mode, track_mode;
  assign div_mode   = op_mode[1];
  assign free_mode  = (op_mode == 2'b01);
  assign track_mode = (op_mode == 2'b00);

  logic [FW-1:0] last_cnt, half_cnt, pt_a, pt_b, hi_start;
  assign last_cnt = len_cept ? FW'(CEPT_LEN - 1)     : FW'(T1_LEN - 1);
  assign half_cnt = len_cept ? FW'(CEPT_LEN / 2)     : FW'(T1_LEN / 2);
  assign pt_a     = len_cept ? FW'(CEPT_LEN / 4)     : FW'(T1_LEN / 4);
  assign pt_b     = len_cept ? FW'(3 * CEPT_LEN / 4) : FW'(3 * T1_LEN / 4);
  assign hi_start = len_cept ? FW'(CEPT_HI)          : FW'(T1_HI);

  logic ref_edge, cmp, ahead, at_point, stall, advance, line_end, frame_wrap;
  assign ref_edge   = edge_rise ? (ref_in & ~ref_q) : (~ref_in & ref_q);
  assign cmp        = track_mode & ref_edge;
  assign ahead      = (frame_cnt != '0) && (frame_cnt < half_cnt);
  assign at_point   = (tick_cnt == '0) && (frame_cnt == pt_a || frame_cnt == pt_b);
  assign stall      = mtick & ~div_mode & (armed | free_mode) & at_point & ~stalled;
  assign advance    = mtick & ~stall;
  assign line_end   = div_mode | (tick_cnt == TW'(TPL - 1));
  assign frame_wrap = advance & line_end & (frame_cnt == last_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_cnt  <= '0;
      frame_cnt <= '0;
      stalled   <= 1'b0;
      armed     <= 1'b0;
      ref_q     <= 1'b1;
      good_cnt  <= '0;
      locked_q  <= 1'b0;
    end else begin
      ref_q <= ref_in;
      if (advance) begin
        stalled  <= 1'b0;
        tick_cnt <= line_end ? '0 : tick_cnt + 1'b1;
        if (line_end)
          frame_cnt <= (frame_cnt == last_cnt) ? '0 : frame_cnt + 1'b1;
      end else if (stall) begin
        stalled <= 1'b1;
      end
      if (cmp && ahead)                 armed <= 1'b1;
      else if (frame_wrap || !track_mode) armed <= 1'b0;
      if (!track_mode) begin
        good_cnt <= '0;
        locked_q <= 1'b0;
      end else if (cmp) begin
        if (ahead) begin
          good_cnt <= '0;
          locked_q <= 1'b0;
        end else if (good_cnt == LW'(LOCK_RUN - 1)) begin
          locked_q <= 1'b1;
        end else begin
          good_cnt <= good_cnt + 1'b1;
        end
      end
    end
  end

  assign line_clk = ~div_mode & tick_cnt[TW-1];
  assign frame_8k = (frame_cnt >= hi_start);
  assign locked   = locked_q;

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (tick_cnt == '0 && frame_cnt == '0 && !locked_q));
  a_r2_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !mtick |=> ($stable(tick_cnt) && $stable(frame_cnt)));
  a_r10_stall_at_point: assert property (@(posedge clk) disable iff (!rst_n)
    stalled |-> (tick_cnt == '0 && (frame_cnt == pt_a || frame_cnt == pt_b)));
  a_r10_single_swallow: assert property (@(posedge clk) disable iff (!rst_n)
    (stalled && mtick) |=> !stalled);
  a_r8_div_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (div_mode && mtick && frame_cnt != last_cnt) |=> (frame_cnt != $past(frame_cnt)));
  a_r9_lock_from_compare: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_q) |-> $past(cmp));
endmodule

// File: tb/sim_pulse_stretch_dpll.sv
`timescale 1ns/1ps
module sim_pulse_stretch_dpll;
  logic clk = 1'b0, rst_n = 1'b0, mtick = 1'b0, ref_in = 1'b1;
  logic len_cept = 1'b0, edge_rise = 1'b0;
  logic [1:0] op_mode = 2'b00;
  logic line_clk, frame_8k, locked;
  int checks = 0, fails = 0, tcount = 0;

  pulse_stretch_dpll u0 (.clk(clk), .rst_n(rst_n), .mtick(mtick), .ref_in(ref_in),
    .len_cept(len_cept), .edge_rise(edge_rise), .op_mode(op_mode),
    .line_clk(line_clk), .frame_8k(frame_8k), .locked(locked));

  always #2 clk = ~clk;
  always @(posedge clk) if (!rst_n) tcount <= 0; else if (mtick) tcount <= tcount + 1;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic cept, input logic rise, input logic [1:0] md);
    @(negedge clk);
    rst_n = 1'b0; mtick = 1'b1; ref_in = 1'b1;
    len_cept = cept; edge_rise = rise; op_mode = md;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_t(input int t);
    while (tcount < t) @(negedge clk);
  endtask

  task automatic wait_rise(output int t);
    logic prev;
    prev = frame_8k;
    forever begin
      @(negedge clk);
      if (frame_8k && !prev) break;
      prev = frame_8k;
    end
    t = tcount;
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst_n = 1'b0; mtick = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 line_clk", line_clk, 0);
    chk("R1 frame_8k", frame_8k, 0);
    chk("R1 locked", locked, 0);
  endtask

  task automatic t_no_edges;
    int t;
    do_reset(1'b0, 1'b1, 2'b00);
    wait_t(7);  chk("R2 line low", line_clk, 0);
    wait_t(8);  chk("R2 line high", line_clk, 1);
    wait_t(16); chk("R2 line low again", line_clk, 0);
    wait_rise(t); chk("R3 first rise", t, 1040);
    wait_rise(t); chk("R3 second rise", t, 3088 + 1040);
    wait_rise(t); chk("R3 third rise", t, 2 * 3088 + 1040);
    chk("R9 no lock without edges", locked, 0);
  endtask

  task automatic t_free;
    int t;
    do_reset(1'b0, 1'b0, 2'b01);
    wait_rise(t); chk("R7 R10 free rise 0", t, 1041);
    wait_rise(t); chk("R7 free rise 1", t, 3088 + 1043);
    wait_rise(t); chk("R7 free rise 2", t, 2 * 3088 + 1045);
    chk("R9 locked low in free run", locked, 0);
  endtask

  task automatic t_lock_fall;
    int t;
    do_reset(1'b0, 1'b0, 2'b00);
    for (int i = 0; i < 5; i++) begin
      wait_t(i * 3088 + 2608); ref_in = 1'b0;
      wait_t((i + 1) * 3088 + 160); ref_in = 1'b1;
      if (i == 2) chk("R9 not locked after 3", locked, 0);
      if (i == 3) chk("R9 locked after 4", locked, 1);
      if (i == 4) chk("R6 rising edges ignored", locked, 1);
    end
    wait_t(5 * 3088 + 320); ref_in = 1'b0;
    wait_t(5 * 3088 + 330);
    chk("R9 lock drops on ahead", locked, 0);
    wait_rise(t); chk("R5 stretched rise", t, 5 * 3088 + 1041);
    wait_rise(t); chk("R5 R4 next rise", t, 6 * 3088 + 1042);
  endtask

  task automatic t_cept_rise;
    int t;
    do_reset(1'b1, 1'b1, 2'b00);
    wait_t(300);  ref_in = 1'b0;
    wait_t(3200); ref_in = 1'b1;
    wait_rise(t); chk("R4 R6 behind edge no stretch", t, 4096 + 2048);
    wait_t(7000); ref_in = 1'b0;
    wait_t(8352); ref_in = 1'b1;
    wait_rise(t); chk("R5 cept stretched rise", t, 8192 + 2048 + 1);
    wait_rise(t); chk("R5 cept next rise", t, 3 * 4096 + 2048 + 2);
    chk("R9 cept not locked", locked, 0);
  endtask

  task automatic t_divide(input logic cept);
    int highs = 0, lines = 0, first = -1;
    do_reset(cept, 1'b0, 2'b10);
    for (int k = 1; k <= (cept ? 256 : 193); k++) begin
      if (k > 1) @(negedge clk);
      highs += frame_8k;
      lines += line_clk;
      if (frame_8k && first < 0) first = tcount;
    end
    chk("R8 high count", highs, 128);
    chk("R8 first high", first, cept ? 128 : 65);
    chk("R8 line_clk low", lines, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_no_edges();
    t_free();
    t_lock_fall();
    t_cept_rise();
    t_divide(1'b0);
    t_divide(1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule